// File: doc/BRIEF.md
# Microprogrammed Instruction Control Unit

This block sequences an 8-bit load/store processor that uses 20-bit instruction words. When an instruction is fetched, the block latches it into an internal instruction register. It then slices out the operand fields: two source register specifiers, a destination specifier, a shift amount, an 8-bit immediate or address, and an 8-bit jump target. The block then walks a short micro-sequence. A fetch step comes first, then a decode step, then one or two execute steps. The datapath strobes for every execute step are read from a control-word ROM addressed by opcode and micro-step. No hardwired per-instruction logic produces them.

The surrounding datapath supplies the instruction word and the ALU zero flag. The datapath acts on the strobes: register write, ALU operand source and operation, memory read and write, program-counter load or increment, and the branch indication. The program counter advances once per instruction, in the final micro-step, unless that step loads a new target.

Top module: `ucp_ctrl_unit`

## Requirements
- R1: While reset (`rst_n` low) is held and in the first cycle after it, `ustep` is 0 and `ir_load` is 1. In that cycle `reg_write`, `mem_rd`, `mem_wr`, `pc_load`, `pc_inc` and `branch` are all 0.
- R2: Each instruction passes through a fixed set of micro-steps. Step 0 is fetch, where `ir_load` is 1. Step 1 is decode, where all strobes are 0. Execution starts at step 2. Only lw continues to step 3. After the final step, `ustep` returns to 0.
- R3: The instruction is sampled only in the fetch step. The outputs show the latched copy: `rd_a`=bits 15:12, `rd_b`=bits 11:8, `shamt`=bits 3:0, `imm`=bits 7:0 and `jump_target`=bits 15:8. Changes to `instr` after fetch have no effect until the next fetch.
- R4: The opcode is held in bits 19:16, with this mapping: sw=0, and=1, srl=2, addi=3, ori=4, nor=5, andi=6, sll=7, or=8, add=9, sub=10, bneq=11, beq=12, lw=13, j=14, subi=15.
- R5: In execute steps, `alu_op` uses these codes: ADD=0, SUB=1, AND=2, OR=3, NOR=4, SLL=5, SRL=6. The ALU op follows the instruction; sw and lw use ADD, and beq and bneq use SUB. `alu_src_imm` is 1 exactly for addi, subi, andi, ori, sw and lw.
- R6: `reg_write` is raised only in the final execute step of add, sub, and, or, nor, sll, srl, addi, subi, andi, ori and lw. The three-register forms name their destination in bits 7:4. The immediate forms and lw name it in bits 11:8, and `wr_reg` carries that destination.
- R7: When the destination specifier is 0, `reg_write` stays 0.
- R8: sw raises `mem_wr` in step 2. lw raises `mem_rd` in steps 2 and 3 and writes the register only in step 3. `mem_rd` and `mem_wr` are never 1 together.
- R9: In the execute step of beq or bneq, `branch` is 1. beq raises `pc_load` when `alu_zero` is 1, and bneq raises it when `alu_zero` is 0. Otherwise `pc_inc` is 1.
- R10: j raises `pc_load` in step 2 when bits 7:0 of the instruction are zero. If those bits are nonzero, the sequence jumps to the unprogrammed step 3. That step acts as a no-op: only `pc_inc` is 1, and the next step is fetch.
- R11: `pc_inc` is 1 in the final step of every instruction that does not load the program counter. `pc_load` and `pc_inc` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 20 | Instruction word from instruction memory |
| alu_zero | input | 1 | ALU result-is-zero flag |
| ir_load | output | 1 | Fetch step: instruction being captured |
| ustep | output | 2 | Current micro-step |
| rd_a | output | 4 | Source register 1 specifier |
| rd_b | output | 4 | Source register 2 specifier |
| shamt | output | 4 | Shift amount |
| imm | output | 8 | Immediate / address field |
| jump_target | output | 8 | Jump target field |
| wr_reg | output | 4 | Destination register specifier |
| reg_write | output | 1 | Register file write enable |
| alu_src_imm | output | 1 | ALU second operand is the immediate |
| alu_op | output | 3 | ALU operation code |
| mem_rd | output | 1 | Data memory read |
| mem_wr | output | 1 | Data memory write |
| pc_load | output | 1 | Load program counter from target |
| pc_inc | output | 1 | Increment program counter |
| branch | output | 1 | Conditional branch executing |

## Verification
The assertions assume that `alu_zero` is a known value in every execute step. They also assume that `instr` is a known value in the fetch step. The block places no other restriction on the instruction word, so every opcode and field value is legal input. The bench sets both inputs on the falling edge before the step that uses them. It scrambles `instr` during the decode and execute steps to show that only the fetch step samples it.

// File: rtl/ucp_pkg.sv
package ucp_pkg;

    localparam int STEP_W = 2;

    typedef enum logic [3:0] {
        OP_SW   = 4'd0,  OP_AND  = 4'd1,  OP_SRL  = 4'd2,  OP_ADDI = 4'd3,
        OP_ORI  = 4'd4,  OP_NOR  = 4'd5,  OP_ANDI = 4'd6,  OP_SLL  = 4'd7,
        OP_OR   = 4'd8,  OP_ADD  = 4'd9,  OP_SUB  = 4'd10, OP_BNEQ = 4'd11,
        OP_BEQ  = 4'd12, OP_LW   = 4'd13, OP_J    = 4'd14, OP_SUBI = 4'd15
    } opcode_e;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0, ALU_SUB = 3'd1, ALU_AND = 3'd2, ALU_OR = 3'd3,
        ALU_NOR = 3'd4, ALU_SLL = 3'd5, ALU_SRL = 3'd6, ALU_PASS = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic    reg_wr;
        logic    dst_rd;      // destination from bits 7:4 (else 11:8)
        logic    src_imm;
        alu_op_e alu;
        logic    mem_rd;
        logic    mem_wr;
        logic    jump;
        logic    br_eq;
        logic    br_ne;
        logic    last;
    } ctrl_word_t;

endpackage

// File: rtl/ucp_rom.sv
module ucp_rom
    import ucp_pkg::*;
(
    input  logic [3:0]        opc,
    input  logic [STEP_W-1:0] step,
    output ctrl_word_t        cw
);
    // Build one execute word: register-writing three-register form
    function automatic ctrl_word_t rtype(input alu_op_e op);
        ctrl_word_t w;
        w = '0;
        w.reg_wr = 1'b1;
        w.dst_rd = 1'b1;
        w.alu    = op;
        w.last   = 1'b1;
        return w;
    endfunction

    function automatic ctrl_word_t itype(input alu_op_e op);
        ctrl_word_t w;
        w = '0;
        w.reg_wr  = 1'b1;
        w.src_imm = 1'b1;
        w.alu     = op;
        w.last    = 1'b1;
        return w;
    endfunction

    always_comb begin
        // unprogrammed entries: no-op that ends the instruction
        cw      = '0;
        cw.alu  = ALU_ADD;
        cw.last = 1'b1;
        if (step == STEP_W'(2)) begin
            case (opc)
                OP_AND:  cw = rtype(ALU_AND);
                OP_OR:   cw = rtype(ALU_OR);
                OP_NOR:  cw = rtype(ALU_NOR);
                OP_ADD:  cw = rtype(ALU_ADD);
                OP_SUB:  cw = rtype(ALU_SUB);
                OP_SLL:  cw = rtype(ALU_SLL);
                OP_SRL:  cw = rtype(ALU_SRL);
                OP_ADDI: cw = itype(ALU_ADD);
                OP_SUBI: cw = itype(ALU_SUB);
                OP_ANDI: cw = itype(ALU_AND);
                OP_ORI:  cw = itype(ALU_OR);
                OP_SW: begin
                    cw.src_imm = 1'b1;
                    cw.mem_wr  = 1'b1;
                end
                OP_LW: begin
                    cw.src_imm = 1'b1;
                    cw.mem_rd  = 1'b1;
                    cw.last    = 1'b0;
                end
                OP_BEQ: begin
                    cw.alu   = ALU_SUB;
                    cw.br_eq = 1'b1;
                end
                OP_BNEQ: begin
                    cw.alu   = ALU_SUB;
                    cw.br_ne = 1'b1;
                end
                OP_J:    cw.jump = 1'b1;
                default: ;
            endcase
        end else if (step == STEP_W'(3) && opc == OP_LW) begin
            cw        = itype(ALU_ADD);
            cw.mem_rd = 1'b1;
        end
    end
endmodule

// File: rtl/ucp_fields.sv
module ucp_fields #(
    parameter int INSTR_W = 20,
    parameter int OPC_W   = 4,
    parameter int REG_W   = 4,
    parameter int IMM_W   = 8
) (
    input  logic [INSTR_W-1:0] ir,
    output logic [OPC_W-1:0]   opc,
    output logic [REG_W-1:0]   rs1,
    output logic [REG_W-1:0]   rs2,
    output logic [REG_W-1:0]   rd,
    output logic [REG_W-1:0]   sa,
    output logic [IMM_W-1:0]   imm8,
    output logic [IMM_W-1:0]   tgt,
    output logic               j_tail_nz
);
    localparam int BODY_TOP = INSTR_W - OPC_W - 1;
    localparam int RS2_TOP  = BODY_TOP - REG_W;

    always_comb begin
        opc       = ir[INSTR_W-1 -: OPC_W];
        rs1       = ir[BODY_TOP -: REG_W];
        rs2       = ir[RS2_TOP -: REG_W];
        rd        = ir[IMM_W-1 -: REG_W];
        sa        = ir[REG_W-1:0];
        imm8      = ir[IMM_W-1:0];
        tgt       = ir[BODY_TOP -: IMM_W];
        j_tail_nz = |ir[IMM_W-1:0];
    end
endmodule

// File: rtl/ucp_ctrl_unit.sv
module ucp_ctrl_unit
    import ucp_pkg::*;
#(
    parameter int INSTR_W = 20,
    parameter int OPC_W   = 4,
    parameter int REG_W   = 4,
    parameter int IMM_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr,
    input  logic               alu_zero,
    output logic               ir_load,
    output logic [STEP_W-1:0]  ustep,
    output logic [REG_W-1:0]   rd_a,
    output logic [REG_W-1:0]   rd_b,
    output logic [REG_W-1:0]   shamt,
    output logic [IMM_W-1:0]   imm,
    output logic [IMM_W-1:0]   jump_target,
    output logic [REG_W-1:0]   wr_reg,
    output logic               reg_write,
    output logic               alu_src_imm,
    output logic [2:0]         alu_op,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic               pc_load,
    output logic               pc_inc,
    output logic               branch
);
    localparam logic [STEP_W-1:0] ST_FETCH  = STEP_W'(0);
    localparam logic [STEP_W-1:0] ST_DECODE = STEP_W'(1);
    localparam logic [STEP_W-1:0] ST_EXEC   = STEP_W'(2);
    localparam logic [STEP_W-1:0] ST_SPARE  = STEP_W'(3);

    typedef struct packed {
        logic [INSTR_W-1:0] ir;
        logic [STEP_W-1:0]  step;
    } state_t;

    state_t st_d, st_q;

    logic [OPC_W-1:0] opc;
    logic [REG_W-1:0] rd_f;
    logic             j_tail_nz;
    ctrl_word_t       cw_rom, cw;
    logic             in_exec;

    ucp_fields #(
        .INSTR_W(INSTR_W), .OPC_W(OPC_W), .REG_W(REG_W), .IMM_W(IMM_W)
    ) u_fields (
        .ir(st_q.ir), .opc(opc), .rs1(rd_a), .rs2(rd_b), .rd(rd_f),
        .sa(shamt), .imm8(imm), .tgt(jump_target), .j_tail_nz(j_tail_nz)
    );

    ucp_rom u_rom (
        .opc(opc[3:0]), .step(st_q.step), .cw(cw_rom)
    );

    always_comb begin
        in_exec = (st_q.step == ST_EXEC) || (st_q.step == ST_SPARE);
        cw      = in_exec ? cw_rom : '0;

        st_d = st_q;
        case (st_q.step)
            ST_FETCH: begin
                st_d.ir   = instr;
                st_d.step = ST_DECODE;
            end
            ST_DECODE:
                st_d.step = (opc == OP_J && j_tail_nz) ? ST_SPARE : ST_EXEC;
            default:
                st_d.step = cw.last ? ST_FETCH : st_q.step + STEP_W'(1);
        endcase

        ir_load     = (st_q.step == ST_FETCH);
        ustep       = st_q.step;
        wr_reg      = cw.dst_rd ? rd_f : rd_b;
        reg_write   = cw.reg_wr && (wr_reg != '0);
        alu_src_imm = cw.src_imm;
        alu_op      = cw.alu;
        mem_rd      = cw.mem_rd;
        mem_wr      = cw.mem_wr;
        branch      = cw.br_eq | cw.br_ne;
        pc_load     = cw.jump | (cw.br_eq & alu_zero) | (cw.br_ne & ~alu_zero);
        pc_inc      = cw.last & ~pc_load;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ucp_ctrl_checker.sv
module ucp_ctrl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ir_load,
    input logic [1:0] ustep,
    input logic [3:0] rd_a,
    input logic [3:0] rd_b,
    input logic [7:0] imm,
    input logic [3:0] wr_reg,
    input logic       reg_write,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       pc_load,
    input logic       pc_inc,
    input logic       branch
);
    assert_fetch_then_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ir_load |=> (ustep == 2'd1));

    assert_decode_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ustep == 2'd1) |-> !(reg_write || mem_rd || mem_wr || pc_load || pc_inc || branch));

    assert_end_returns_fetch_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load || pc_inc) |=> ir_load);

    assert_fields_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ustep != 2'd0) |=> ($stable(rd_a) && $stable(rd_b) && $stable(imm)));

    assert_no_zero_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_write |-> (wr_reg != 4'd0));

    assert_mem_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_pc_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pc_load, pc_inc}));

    assert_branch_resolves_R9: assert property (@(posedge clk) disable iff (!rst_n)
        branch |-> (pc_load || pc_inc));
endmodule

bind ucp_ctrl_unit ucp_ctrl_checker u_chk (
    .clk(clk), .rst_n(rst_n), .ir_load(ir_load), .ustep(ustep),
    .rd_a(rd_a), .rd_b(rd_b), .imm(imm), .wr_reg(wr_reg),
    .reg_write(reg_write), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .pc_load(pc_load), .pc_inc(pc_inc), .branch(branch)
);

// File: tb/ucp_ctrl_unit_test.sv
module ucp_ctrl_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] instr = '0;
    logic        alu_zero = 1'b0;
    logic        ir_load;
    logic [1:0]  ustep;
    logic [3:0]  rd_a, rd_b, shamt, wr_reg;
    logic [7:0]  imm, jump_target;
    logic        reg_write, alu_src_imm, mem_rd, mem_wr, pc_load, pc_inc, branch;
    logic [2:0]  alu_op;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ucp_ctrl_unit uut (
        .clk(clk), .rst_n(rst_n), .instr(instr), .alu_zero(alu_zero),
        .ir_load(ir_load), .ustep(ustep), .rd_a(rd_a), .rd_b(rd_b),
        .shamt(shamt), .imm(imm), .jump_target(jump_target), .wr_reg(wr_reg),
        .reg_write(reg_write), .alu_src_imm(alu_src_imm), .alu_op(alu_op),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .pc_load(pc_load), .pc_inc(pc_inc),
        .branch(branch)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Strobe vector: {reg_write, alu_src_imm, alu_op[2:0], mem_rd, mem_wr, pc_load, pc_inc, branch}
    function automatic logic [9:0] strobes();
        return {reg_write, alu_src_imm, alu_op, mem_rd, mem_wr, pc_load, pc_inc, branch};
    endfunction

    // Expected strobes for an execute step, derived from R4..R11
    function automatic logic [9:0] model(input logic [19:0] ins, input logic z,
                                         input logic second);
        logic [3:0] op;
        logic wr, src, mr, mw, ld, br, fin;
        logic [2:0] a;
        op = ins[19:16];
        wr = 0; src = 0; mr = 0; mw = 0; ld = 0; br = 0; a = 3'd0; fin = 1;
        case (op)
            4'd0:  begin src = 1; mw = 1; end
            4'd1:  begin wr = 1; a = 3'd2; end
            4'd2:  begin wr = 1; a = 3'd6; end
            4'd3:  begin wr = 1; src = 1; a = 3'd0; end
            4'd4:  begin wr = 1; src = 1; a = 3'd3; end
            4'd5:  begin wr = 1; a = 3'd4; end
            4'd6:  begin wr = 1; src = 1; a = 3'd2; end
            4'd7:  begin wr = 1; a = 3'd5; end
            4'd8:  begin wr = 1; a = 3'd3; end
            4'd9:  begin wr = 1; a = 3'd0; end
            4'd10: begin wr = 1; a = 3'd1; end
            4'd11: begin br = 1; a = 3'd1; ld = !z; end
            4'd12: begin br = 1; a = 3'd1; ld = z; end
            4'd13: begin src = 1; mr = 1; wr = second; fin = second; end
            4'd14: ld = (ins[7:0] == 8'd0);
            default: begin wr = 1; src = 1; a = 3'd1; end
        endcase
        if (wr && dest(ins) == 4'd0) wr = 0;
        return {wr, src, a, mr, mw, ld, fin && !ld, br};
    endfunction

    function automatic logic [3:0] dest(input logic [19:0] ins);
        logic [3:0] op;
        op = ins[19:16];
        if (op == 4'd1 || op == 4'd2 || op == 4'd5 || op == 4'd7 ||
            op == 4'd8 || op == 4'd9 || op == 4'd10)
            return ins[7:4];
        return ins[11:8];
    endfunction

    // Runs one instruction from fetch to fetch; call at a falling edge in step 0.
    task automatic run_op(input string req, input logic [19:0] ins, input logic z);
        logic [3:0] op;
        logic [9:0] e;
        op = ins[19:16];
        check("R2", "fetch step", {ustep, ir_load}, {2'd0, 1'b1});
        instr = ins;
        alu_zero = z;
        @(negedge clk);
        check("R2", "decode step", {ustep, strobes()}, {2'd1, 10'd0});
        instr = ~ins;   // must be ignored (R3)
        @(negedge clk);
        if (op == 4'd14 && ins[7:0] != 8'd0) begin
            check("R10", "malformed j goes to spare step", 32'(ustep), 32'd3);
        end else begin
            check("R2", "first execute step", 32'(ustep), 32'd2);
        end
        e = model(ins, z, 1'b0);
        check(req, "execute strobes", 32'(strobes()), 32'(e));
        check("R3", "latched fields", {rd_a, rd_b, shamt, imm, jump_target},
              {ins[15:12], ins[11:8], ins[3:0], ins[7:0], ins[15:8]});
        if (e[9]) check("R6", "destination", 32'(wr_reg), 32'(dest(ins)));
        if (op == 4'd13) begin
            @(negedge clk);
            check("R8", "lw second step", 32'(ustep), 32'd3);
            e = model(ins, z, 1'b1);
            check("R8", "lw writeback strobes", 32'(strobes()), 32'(e));
            if (e[9]) check("R6", "lw destination", 32'(wr_reg), 32'(dest(ins)));
        end
        @(negedge clk);
        check("R2", "back to fetch", {ustep, ir_load}, {2'd0, 1'b1});
    endtask

    task automatic t_reset();
        check("R1", "reset state", {ustep, ir_load, reg_write, mem_rd, mem_wr,
              pc_load, pc_inc, branch}, {2'd0, 1'b1, 6'd0});
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", "first cycle after reset", {ustep, ir_load, strobes()},
              {2'd0, 1'b1, 10'd0});
    endtask

    task automatic t_alu_ops();
        // R4 R5 R6: three-register forms, dest in bits 7:4
        run_op("R5", {4'd9,  4'd1, 4'd2, 4'd3, 4'd0}, 1'b0); // add
        run_op("R5", {4'd10, 4'd4, 4'd5, 4'd1, 4'd0}, 1'b0); // sub
        run_op("R5", {4'd1,  4'd2, 4'd3, 4'd4, 4'd0}, 1'b0); // and
        run_op("R5", {4'd8,  4'd3, 4'd1, 4'd5, 4'd0}, 1'b0); // or
        run_op("R5", {4'd5,  4'd5, 4'd4, 4'd2, 4'd0}, 1'b0); // nor
        run_op("R4", {4'd7,  4'd1, 4'd0, 4'd2, 4'd3}, 1'b0); // sll
        run_op("R4", {4'd2,  4'd2, 4'd0, 4'd3, 4'd7}, 1'b0); // srl
        // immediate forms, dest in bits 11:8
        run_op("R6", {4'd3,  4'd1, 4'd2, 8'h5A}, 1'b0);      // addi
        run_op("R6", {4'd15, 4'd3, 4'd4, 8'h01}, 1'b0);      // subi
        run_op("R6", {4'd6,  4'd4, 4'd5, 8'hF0}, 1'b0);      // andi
        run_op("R6", {4'd4,  4'd5, 4'd1, 8'h0F}, 1'b0);      // ori
    endtask

    task automatic t_zero_dest();
        run_op("R7", {4'd9, 4'd1, 4'd2, 4'd0, 4'd0}, 1'b0);  // add to $zero
        run_op("R7", {4'd3, 4'd1, 4'd0, 8'h22}, 1'b0);       // addi to $zero
        run_op("R7", {4'd13, 4'd1, 4'd0, 8'h04}, 1'b0);      // lw to $zero
    endtask

    task automatic t_memory();
        run_op("R8", {4'd0,  4'd5, 4'd1, 8'h10}, 1'b0);      // sw
        run_op("R8", {4'd13, 4'd5, 4'd3, 8'h04}, 1'b0);      // lw
    endtask

    task automatic t_branches();
        run_op("R9", {4'd12, 4'd1, 4'd2, 8'h40}, 1'b1);      // beq taken
        run_op("R9", {4'd12, 4'd1, 4'd2, 8'h40}, 1'b0);      // beq not taken
        run_op("R9", {4'd11, 4'd3, 4'd4, 8'h20}, 1'b0);      // bneq taken
        run_op("R9", {4'd11, 4'd3, 4'd4, 8'h20}, 1'b1);      // bneq not taken
    endtask

    task automatic t_jump();
        run_op("R10", {4'd14, 8'hA7, 8'h00}, 1'b0);          // well-formed j
        run_op("R10", {4'd14, 8'hA7, 8'h01}, 1'b0);          // low bits set: no-op
        run_op("R11", {4'd14, 8'h00, 8'h80}, 1'b1);          // no-op ignores zero flag
    endtask

    initial begin
        fork
            begin
                @(negedge clk);
                t_reset();
                t_alu_ops();
                t_zero_dest();
                t_memory();
                t_branches();
                t_jump();
                done = 1'b1;
            end
            begin
                repeat (5000) @(posedge clk);
                if (!done) begin
                    n_chk++;
                    n_bad++;
                    $display("FAIL watchdog: actual hung expected completion");
                end
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule